// File: doc/BRIEF.md
# Late-Write Flowthrough Synchronous SRAM

A small synchronous static memory that accepts one command on every enabled clock edge: load-read, load-write, burst continue or deselect. A read is flowthrough. The edge that registers the read address also selects the stored word, and that word reaches the output port in the same cycle through logic alone, with no output register. A write is late. The edge that registers the write address and byte enables holds them in a write-delay register. The data word is then sampled on the next enabled edge. Because of this split, reads and writes can alternate on every edge with no idle cycle between them.

A burst counter steps the two low address bits for up to four beats from a loaded base, in linear or interleaved order. A burst-continue cycle repeats the type of the last load. Three chip selects qualify every load. A clock enable freezes the block for a cycle. An output enable gates the read port without any clock. A sleep input makes the block ignore its other inputs. After sleep is released, the block drops writes for a short recovery window and still serves reads.

Top module: `lwft_sram`

## Requirements
- R1: A write command registers its address and byte enables on edge k. The data word on `wdata` is sampled and stored on the next enabled edge k+1.
- R2: After an edge that registers a read of address A, `rdata` holds the word at A and `rdata_en` is 1 within that same cycle, before any further edge. This assumes `oe_n` is low.
- R3: `byte_we_n[i]` low writes bits 8i+7..8i of the word. A lane whose `byte_we_n[i]` is high keeps its old contents.
- R4: Commands may alternate on every edge with no dead cycle. A read registered on the edge that takes a write's data returns the new word merged per lane, if the read is to the same address.
- R5: When `clk_en` is low, an edge changes nothing. A pending write is not committed, and the sampled data comes from the next enabled edge. `rdata` keeps showing the previous read.
- R6: `oe_n` high forces `rdata` to 0 and `rdata_en` to 0 at once, without a clock edge. Returning `oe_n` low restores the read word.
- R7: A load is accepted only when `cs0`=1, `cs1_n`=0 and `cs2_n`=0. Otherwise the load is a deselect: `rdata_en` is 0 after that edge and no write takes place.
- R8: `adv`=1 continues the last accepted load with the same type. Each beat changes only address bits [1:0]. Beat n (n=1..3) is base+n mod 4 when `burst_linear`=1, and base XOR n when `burst_linear`=0.
- R9: While `sleep`=1, all other inputs are ignored and `rdata_en` is 0. After `sleep` falls, write commands on the first RECOV enabled edges are dropped, while reads are served.
- R10: After reset, `rdata_en` is 0, no write is pending and no burst is active. An `adv`=1 edge right after reset is therefore a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable, active high |
| cs0 | input | 1 | Chip select, active high |
| cs1_n | input | 1 | Chip select, active low |
| cs2_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = burst continue, 0 = load |
| we | input | 1 | On a load: 1 = write, 0 = read |
| byte_we_n | input | DW/8 | Per-lane write enables, active low |
| addr | input | AW | Load address |
| burst_linear | input | 1 | 1 = linear burst order, 0 = interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request |
| wdata | input | DW | Write data, sampled one enabled edge after the write command |
| rdata | output | DW | Flowthrough read data, 0 when not driven |
| rdata_en | output | 1 | Read data is being driven |

## Verification
Two things can land on the same edge: the commit of a late write's data, and the registration of a new read to that same address. The bench provokes this by issuing a partial-lane write and, on the very next edge, a read of that address while the data word is on `wdata`. The read is judged correct only if `rdata` in that cycle shows the new lanes merged with the old ones. A second case puts a stalled edge (`clk_en` low) between the write command and its data. This proves that the data that lands is the word present at the next enabled edge.

// File: rtl/lwft_sram.sv
module lwft_sram #(
  parameter int AW    = 6,
  parameter int DW    = 32,
  parameter int RECOV = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_en,
  input  logic            cs0,
  input  logic            cs1_n,
  input  logic            cs2_n,
  input  logic            adv,
  input  logic            we,
  input  logic [DW/8-1:0] byte_we_n,
  input  logic [AW-1:0]   addr,
  input  logic            burst_linear,
  input  logic            oe_n,
  input  logic            sleep,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            rdata_en
);
  localparam int NL  = DW / 8;
  localparam int RCW = $clog2(RECOV + 1);

  logic [DW-1:0] mem [2**AW];

  logic          rd_act_q, wpend_q, bact_q, bwr_q;
  logic [1:0]    cnt_q;
  logic [AW-1:0] base_q, rd_addr_q, wa_q;
  logic [NL-1:0] bw_q;
  logic [RCW-1:0] rcnt_q;

  logic go, sel, rec_ok, do_rd, do_wr;
  logic [1:0] nxt_cnt, lo;
  logic [AW-1:0] cur_addr;

  assign go       = clk_en & ~sleep;
  assign sel      = cs0 & ~cs1_n & ~cs2_n;
  assign rec_ok   = (rcnt_q == '0);
  assign nxt_cnt  = cnt_q + 2'd1;
  assign lo       = burst_linear ? (base_q[1:0] + nxt_cnt) : (base_q[1:0] ^ nxt_cnt);
  assign cur_addr = adv ? {base_q[AW-1:2], lo} : addr;
  assign do_rd    = adv ? (bact_q & ~bwr_q) : (sel & ~we);
  assign do_wr    = rec_ok & (adv ? (bact_q & bwr_q) : (sel & we));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q  <= 1'b0;
      wpend_q   <= 1'b0;
      bact_q    <= 1'b0;
      bwr_q     <= 1'b0;
      cnt_q     <= '0;
      base_q    <= '0;
      rd_addr_q <= '0;
      wa_q      <= '0;
      bw_q      <= '0;
      rcnt_q    <= '0;
    end else begin
      if (sleep)
        rcnt_q <= RECOV[RCW-1:0];
      else if (clk_en && !rec_ok)
        rcnt_q <= rcnt_q - 1'b1;
      if (go) begin
        rd_act_q  <= do_rd;
        wpend_q   <= do_wr;
        rd_addr_q <= cur_addr;
        wa_q      <= cur_addr;
        bw_q      <= ~byte_we_n;
        if (!adv) begin
          base_q <= addr;
          cnt_q  <= '0;
          bact_q <= sel;
          bwr_q  <= we;
        end else if (bact_q) begin
          cnt_q <= nxt_cnt;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (go && wpend_q)
      for (int i = 0; i < NL; i++)
        if (bw_q[i]) mem[wa_q][8*i +: 8] <= wdata[8*i +: 8];
  end

  assign rdata_en = rd_act_q & ~oe_n & ~sleep;
  assign rdata    = rdata_en ? mem[rd_addr_q] : '0;

  a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en) |=> ($stable(rd_addr_q) && $stable(wpend_q) && $stable(cnt_q)));

  a_r7_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !adv && !sel) |=> (!rd_act_q && !wpend_q));

  a_r8_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (go && adv && bact_q) |=> (cnt_q == $past(cnt_q) + 2'd1));

  a_r9_recov_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (go && rcnt_q != '0) |=> !wpend_q);

  a_r9_sleep_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep) |=> ($stable(base_q) && $stable(rd_act_q)));
endmodule

// File: tb/lwft_sram_tb.sv
module lwft_sram_tb_top;
  logic        clk = 0, rst_n = 0, clk_en = 1, cs0 = 1, cs1_n = 0, cs2_n = 0;
  logic        adv = 0, we = 0, burst_linear = 1, oe_n = 0, sleep = 0;
  logic [3:0]  byte_we_n = 4'hf;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        rdata_en;
  int checks = 0, errors = 0;

  localparam logic [31:0] D1 = 32'hCAFE_0001;

  always #5 clk = ~clk;

  lwft_sram #(.AW(6), .DW(32), .RECOV(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cs0(cs0), .cs1_n(cs1_n), .cs2_n(cs2_n),
    .adv(adv), .we(we), .byte_we_n(byte_we_n), .addr(addr), .burst_linear(burst_linear),
    .oe_n(oe_n), .sleep(sleep), .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en));

  task automatic step(); @(posedge clk); #2; endtask

  task automatic ld(input logic w, input logic [5:0] a, input logic [3:0] bn = 4'h0);
    adv = 0; we = w; addr = a; byte_we_n = bn;
  endtask

  task automatic cont(); adv = 1; byte_we_n = 4'h0; endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R10 rdata_en in reset", {31'd0, rdata_en}, 32'd0);
    repeat (2) @(posedge clk);
    #2 rst_n = 1;
    cont(); step();
    chk("R10 adv after reset is deselect", {31'd0, rdata_en}, 32'd0);
  endtask

  task automatic t_write_read();
    ld(1, 6'd5); step();
    wdata = D1; ld(0, 6'd5); step();
    chk("R1 R4 read after write same addr", rdata, D1);
    chk("R2 rdata_en on read", {31'd0, rdata_en}, 32'd1);
    ld(1, 6'd6); step();
    wdata = 32'h1122_3344; ld(1, 6'd6, 4'b1010); step();
    wdata = 32'hAABB_CCDD; ld(0, 6'd6); step();
    chk("R3 R4 lane merge forwarded", rdata, 32'h11BB_33DD);
    ld(0, 6'd5); step();
    chk("R2 flowthrough read", rdata, D1);
  endtask

  task automatic t_alternate();
    ld(1, 6'd7); step();
    wdata = 32'h7777_0007; ld(0, 6'd5); step();
    chk("R4 alt read 1", rdata, D1);
    ld(1, 6'd8); step();
    wdata = 32'h8888_0008; ld(0, 6'd7); step();
    chk("R4 alt read 2", rdata, 32'h7777_0007);
    ld(0, 6'd8); step();
    chk("R4 alt read 3", rdata, 32'h8888_0008);
  endtask

  task automatic t_oe();
    ld(0, 6'd5); step();
    oe_n = 1; #1;
    chk("R6 oe_n high data", rdata, 32'd0);
    chk("R6 oe_n high en", {31'd0, rdata_en}, 32'd0);
    oe_n = 0; #1;
    chk("R6 oe_n low restores", rdata, D1);
  endtask

  task automatic t_stall();
    ld(0, 6'd5); step();
    clk_en = 0; ld(0, 6'd6); step();
    chk("R5 stall holds read", rdata, D1);
    clk_en = 1; ld(1, 6'd9); step();
    clk_en = 0; wdata = 32'h0BAD_0BAD; step();
    clk_en = 1; wdata = 32'h600D_0009; ld(0, 6'd9); step();
    chk("R5 data from next enabled edge", rdata, 32'h600D_0009);
  endtask

  task automatic t_cs();
    cs0 = 0; ld(0, 6'd5); step();
    chk("R7 cs0 low deselect", {31'd0, rdata_en}, 32'd0);
    cs0 = 1; cs1_n = 1; ld(1, 6'd5); step();
    cs1_n = 0; wdata = 32'hDEAD_DEAD; ld(0, 6'd5); step();
    chk("R7 deselected write ignored", rdata, D1);
    cs2_n = 1; ld(0, 6'd5); step();
    chk("R7 cs2_n high deselect", {31'd0, rdata_en}, 32'd0);
    cs2_n = 0;
  endtask

  task automatic t_burst();
    burst_linear = 1;
    ld(1, 6'h12); step();
    for (int i = 0; i < 3; i++) begin
      wdata = 32'h0B0B_0000 + i; cont(); step();
    end
    wdata = 32'h0B0B_0003; ld(0, 6'h12); step();
    chk("R8 linear beat0", rdata, 32'h0B0B_0000);
    cont(); step(); chk("R8 linear beat1", rdata, 32'h0B0B_0001);
    cont(); step(); chk("R8 linear beat2", rdata, 32'h0B0B_0002);
    cont(); step(); chk("R8 linear beat3", rdata, 32'h0B0B_0003);
    ld(0, 6'h10); step(); chk("R8 linear wrap addr", rdata, 32'h0B0B_0002);
    burst_linear = 0;
    ld(0, 6'h13); step(); chk("R8 interleave beat0", rdata, 32'h0B0B_0001);
    cont(); step(); chk("R8 interleave beat1", rdata, 32'h0B0B_0000);
    cont(); step(); chk("R8 interleave beat2", rdata, 32'h0B0B_0003);
    cont(); step(); chk("R8 interleave beat3", rdata, 32'h0B0B_0002);
    burst_linear = 1;
  endtask

  task automatic t_sleep();
    ld(0, 6'd5); step();
    sleep = 1; #1;
    chk("R9 sleep drops output", {31'd0, rdata_en}, 32'd0);
    ld(1, 6'd5); step();
    sleep = 0; wdata = 32'h5151_5151; ld(1, 6'd5); step();
    wdata = 32'h5252_5252; ld(0, 6'd5); step();
    chk("R9 recovery write dropped read served", rdata, D1);
    ld(1, 6'd5); step();
    wdata = 32'h5353_5353; ld(0, 6'd5); step();
    chk("R9 write after recovery", rdata, 32'h5353_5353);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2;
    t_reset();
    t_write_read();
    t_alternate();
    t_oe();
    t_stall();
    t_cs();
    t_burst();
    t_sleep();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule